// File: doc/BRIEF.md
# Receive Handshake Pattern Detector Bank

This block sits behind a modem demodulator and watches the received serial bit stream for the patterns that mark the stages of a call handshake. Each received bit is marked by a one-cycle bit-valid strobe. The block also watches the output of an external descrambler, which is fed to it bit by bit on the same strobe. Four detectors run side by side. The first finds an alternating 1/0 pattern. The second finds an unbroken run of received ones. The third finds an unbroken run of ones at the descrambler output. The fourth finds an unbroken run of received zeros.

The alternating detector drives a flag of its own. The other three share a two-bit status code, and the most recently detected pattern owns that code. A detection stays visible for twelve bit times after its pattern stops. When the demodulator mode or the bit rate changes, every run and every held detection is dropped at once. The control logic reads these outputs to move through a handshake sequence.

Top module: `rx_pattern_bank`

## Requirements
- R1: `alt_flag` rises only while `fsk_mode` is 1, after 32 consecutive strobed bits in which each bit differs from the previous one. With `fsk_mode` at 0, `alt_flag` stays 0.
- R2: Code 01 appears on `line_code` after 32 consecutive strobed ones on `rx_bit`, whatever the mode. `alt_flag` is registered one clock after the strobe edge, and `line_code` one clock later.
- R3: Code 11 appears after 32 consecutive strobed ones on `descr_bit`, but only when `fsk_mode` is 0 and `descr_en` is 1.
- R4: The descrambled-ones detector is cleared and held idle while the unscrambled-ones detection is active, so code 11 cannot return while code 01 is held.
- R5: Code 10 appears after NX consecutive strobed zeros on `rx_bit`. NX is 2*`char_len`+4 when `fsk_mode` is 0 and `start_stop_en` is 1. In every other case NX is 32.
- R6: Once a pattern stops, its detection stays for 12 more strobes and is cleared on the 13th strobe, unless a full run is seen again.
- R7: A change of `fsk_mode` or `rate_sel` clears all runs, the alternation history, `alt_flag` and `line_code` at the next clock edge.
- R8: Runs advance only on cycles where `bit_valid` is 1. A single bit that breaks a pattern restarts that detector's run count.
- R9: `line_code` reads 00 when no ones or zeros detection is active. When detections overlap, the code belongs to the one detected most recently. If that one ends while another is still held, the code shows the one that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | One-cycle strobe marking a received bit |
| rx_bit | input | 1 | Received data bit from the demodulator |
| descr_bit | input | 1 | Descrambler output bit for the same bit time |
| fsk_mode | input | 1 | 1 = FSK demodulation, 0 = DPSK/QAM |
| start_stop_en | input | 1 | Character (start-stop) framing selected |
| descr_en | input | 1 | Descrambler enabled |
| char_len | input | 4 | Bits per character, counting start, stop and parity |
| rate_sel | input | 2 | Received bit-rate selection |
| alt_flag | output | 1 | Alternating-pattern detection |
| line_code | output | 2 | 00 idle, 01 unscrambled ones, 11 descrambled ones, 10 zeros |

## Verification
The assertions assume that `bit_valid`, the data bits and the mode inputs are driven synchronously and are never unknown after reset. They also assume that a mode or rate change is a plain level change sampled by the clock, not a glitch between edges. The stimulus drives every input on the falling clock edge. Each strobe is one cycle long and is followed by an idle cycle. Mode, rate and framing settings change only between bits, so a change of setting never lands on the same clock as a strobe. Expected values come from hand-counted run lengths against the thresholds in the requirements.

// File: rtl/rxpd_pkg.sv
// Package: shared constants and codes for the receive pattern detector bank.
// Assumes: detector indices are used consistently by the top and the selector.
package rxpd_pkg;

    // Detector slot indices inside the bank
    localparam int DET_ALT   = 0;
    localparam int DET_UNSCR = 1;
    localparam int DET_SCR   = 2;
    localparam int DET_ZERO  = 3;
    localparam int NUM_DET   = 4;

    // Encodings driven on the shared two-bit status field
    typedef enum logic [1:0] {
        CODE_IDLE  = 2'b00,
        CODE_UNSCR = 2'b01,
        CODE_ZERO  = 2'b10,
        CODE_SCR   = 2'b11
    } line_code_e;

    // Which detection currently owns the status field
    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_UNSCR,
        OWN_SCR,
        OWN_ZERO
    } owner_e;

endpackage

// File: rtl/rxpd_front.sv
// Module: rxpd_front
// Purpose: spots mode or rate changes (flush), tracks the previous received
//          bit for the alternation test, and works out the zero-run threshold.
// Assumes: mode inputs are synchronous to clk; char_len is small enough that
//          2*char_len+4 fits RUN_W bits.
module rxpd_front #(
    parameter int RATE_W   = 2,
    parameter int CLEN_W   = 4,
    parameter int RUN_W    = 8,
    parameter int ZERO_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              rx_bit,
    input  logic              fsk_mode,
    input  logic              start_stop_en,
    input  logic [CLEN_W-1:0] char_len,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              flush,
    output logic              alt_match,
    output logic [RUN_W-1:0]  zero_thr
);

    localparam logic [RUN_W-1:0] FRAME_PAD = RUN_W'(4);

    logic              fsk_q;
    logic [RATE_W-1:0] rate_q;
    logic              prev_q;
    logic              prev_vld;

    // Remember the last mode and rate; reset loads the live values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsk_q  <= fsk_mode;
            rate_q <= rate_sel;
        end else begin
            fsk_q  <= fsk_mode;
            rate_q <= rate_sel;
        end
    end

    // Any difference from the stored setting drops all detector state
    always_comb begin
        flush = (fsk_mode != fsk_q) || (rate_sel != rate_q);
    end

    // Keep the previous strobed bit for the alternation test
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            prev_q   <= 1'b0;
            prev_vld <= 1'b0;
        end else if (stb) begin
            prev_q   <= rx_bit;
            prev_vld <= 1'b1;
        end
    end

    // The current bit extends an alternation when it differs from the last one
    always_comb begin
        alt_match = prev_vld && (rx_bit != prev_q);
    end

    // The zero-run length depends on character framing in DPSK/QAM mode only
    always_comb begin
        if (!fsk_mode && start_stop_en)
            zero_thr = RUN_W'({char_len, 1'b0}) + FRAME_PAD;
        else
            zero_thr = RUN_W'(ZERO_LEN);
    end

    // After a flush edge there is no alternation history left (R7)
    p_history_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !alt_match);

endmodule

// File: rtl/rxpd_run_det.sv
// Module: rxpd_run_det
// Purpose: one run-length detector with a post-pattern hold. It counts
//          consecutive matching strobed bits, flags a detection at the
//          threshold, and keeps the flag for HOLD_BITS strobes after the run
//          breaks.
// Assumes: thr >= 2; clr forces the idle state with priority over stb.
module rxpd_run_det #(
    parameter int RUN_W     = 8,
    parameter int HOLD_BITS = 12,
    parameter int HOLD_W    = $clog2(HOLD_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb,
    input  logic             match,
    input  logic             seed,
    input  logic [RUN_W-1:0] thr,
    output logic             det
);

    localparam logic [RUN_W-1:0]  RUN_MAX  = {RUN_W{1'b1}};
    localparam logic [HOLD_W-1:0] HOLD_TOP = HOLD_W'(HOLD_BITS);

    logic [RUN_W-1:0]  run_q;
    logic [RUN_W-1:0]  run_nx;
    logic [HOLD_W-1:0] hold_q;
    logic              full;

    // Next run length: extend and saturate on a match, restart from seed otherwise
    always_comb begin
        if (match)
            run_nx = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        else
            run_nx = RUN_W'(seed);
        full = (run_nx >= thr);
    end

    // Run, detection and hold registers advance on the bit strobe only
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q  <= '0;
            hold_q <= '0;
            det    <= 1'b0;
        end else if (stb) begin
            run_q <= run_nx;
            if (full) begin
                det    <= 1'b1;
                hold_q <= HOLD_TOP;
            end else if (det) begin
                if (hold_q == '0)
                    det <= 1'b0;
                else
                    hold_q <= hold_q - 1'b1;
            end
        end
    end

    // The hold counter never exceeds the configured hold length (R6)
    p_hold_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q <= HOLD_TOP);

    // A new detection starts with a full hold window (R6)
    p_hold_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det) |-> (hold_q == HOLD_TOP));

    // Detections only appear on a strobe edge (R8)
    p_det_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det) |-> $past(stb));

    // A broken bit leaves at most the seed in the run counter (R8)
    p_restart_on_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !match && !clr) |=> (run_q <= RUN_W'(1)));

endmodule

// File: rtl/rxpd_code_sel.sv
// Module: rxpd_code_sel
// Purpose: chooses which of the ones/zeros detections owns the shared two-bit
//          code. A new detection wins; when the owner ends, a remaining held
//          detection takes over.
// Assumes: no two of the inputs rise in the same cycle in normal use; if
//          they do, fixed priority (unscrambled, scrambled, zeros) applies.
module rxpd_code_sel
    import rxpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       det_unscr,
    input  logic       det_scr,
    input  logic       det_zero,
    output logic [1:0] code
);

    owner_e owner_q;
    owner_e owner_d;
    logic   unscr_q;
    logic   scr_q;
    logic   zero_q;
    logic   owner_live;

    // Is the current owner still detecting
    always_comb begin
        unique case (owner_q)
            OWN_UNSCR: owner_live = det_unscr;
            OWN_SCR:   owner_live = det_scr;
            OWN_ZERO:  owner_live = det_zero;
            default:   owner_live = 1'b0;
        endcase
    end

    // Pick the next owner: newest rise first, else keep, else fall back
    always_comb begin
        if (flush)
            owner_d = OWN_NONE;
        else if (det_unscr && !unscr_q)
            owner_d = OWN_UNSCR;
        else if (det_scr && !scr_q)
            owner_d = OWN_SCR;
        else if (det_zero && !zero_q)
            owner_d = OWN_ZERO;
        else if (owner_live)
            owner_d = owner_q;
        else if (det_zero)
            owner_d = OWN_ZERO;
        else if (det_unscr)
            owner_d = OWN_UNSCR;
        else if (det_scr)
            owner_d = OWN_SCR;
        else
            owner_d = OWN_NONE;
    end

    // Register the owner and the previous detection levels for edge finding
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            owner_q <= OWN_NONE;
            unscr_q <= 1'b0;
            scr_q   <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            owner_q <= owner_d;
            unscr_q <= det_unscr;
            scr_q   <= det_scr;
            zero_q  <= det_zero;
        end
    end

    // Map the owner onto the status encoding
    always_comb begin
        unique case (owner_q)
            OWN_UNSCR: code = CODE_UNSCR;
            OWN_SCR:   code = CODE_SCR;
            OWN_ZERO:  code = CODE_ZERO;
            default:   code = CODE_IDLE;
        endcase
    end

    // A fresh zero-run detection takes the code next cycle (R9)
    p_zero_takes_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(det_zero) && !flush) |=> (code == CODE_ZERO));

    // A fresh unscrambled-ones detection takes the code next cycle (R2)
    p_unscr_takes_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(det_unscr) && !flush) |=> (code == CODE_UNSCR));

    // With nothing detected for two cycles the field is idle (R9)
    p_idle_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_unscr && !det_scr && !det_zero && !$past(det_unscr)
         && !$past(det_scr) && !$past(det_zero)) |=> (code == CODE_IDLE));

endmodule

// File: rtl/rx_pattern_bank.sv
// Module: rx_pattern_bank (top)
// Purpose: bank of four handshake pattern detectors on a strobed received bit
//          stream and a supplied descrambler output, with a flag for the
//          alternating pattern and a shared status code for the runs.
// Assumes: bit_valid is a single-cycle strobe per received bit; the
//          descrambler output is aligned with rx_bit on the same strobe.
module rx_pattern_bank
    import rxpd_pkg::*;
#(
    parameter int RUN_W     = 8,
    parameter int HOLD_BITS = 12,
    parameter int ALT_LEN   = 32,
    parameter int ONES_LEN  = 32,
    parameter int ZERO_LEN  = 32,
    parameter int RATE_W    = 2,
    parameter int CLEN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              rx_bit,
    input  logic              descr_bit,
    input  logic              fsk_mode,
    input  logic              start_stop_en,
    input  logic              descr_en,
    input  logic [CLEN_W-1:0] char_len,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              alt_flag,
    output logic [1:0]        line_code
);

    localparam int HOLD_W = $clog2(HOLD_BITS + 1);

    logic             flush;
    logic             alt_match;
    logic [RUN_W-1:0] zero_thr;

    logic             det_en    [NUM_DET];
    logic             det_match [NUM_DET];
    logic             det_seed  [NUM_DET];
    logic [RUN_W-1:0] det_thr   [NUM_DET];
    logic [NUM_DET-1:0] det;

    rxpd_front #(
        .RATE_W   (RATE_W),
        .CLEN_W   (CLEN_W),
        .RUN_W    (RUN_W),
        .ZERO_LEN (ZERO_LEN)
    ) u_front (
        .clk           (clk),
        .rst_n         (rst_n),
        .stb           (bit_valid),
        .rx_bit        (rx_bit),
        .fsk_mode      (fsk_mode),
        .start_stop_en (start_stop_en),
        .char_len      (char_len),
        .rate_sel      (rate_sel),
        .flush         (flush),
        .alt_match     (alt_match),
        .zero_thr      (zero_thr)
    );

    // Per-detector enable, match source, restart seed and run length
    always_comb begin
        det_en[DET_ALT]      = fsk_mode;
        det_match[DET_ALT]   = alt_match;
        det_seed[DET_ALT]    = 1'b1;
        det_thr[DET_ALT]     = RUN_W'(ALT_LEN);

        det_en[DET_UNSCR]    = 1'b1;
        det_match[DET_UNSCR] = rx_bit;
        det_seed[DET_UNSCR]  = 1'b0;
        det_thr[DET_UNSCR]   = RUN_W'(ONES_LEN);

        det_en[DET_SCR]      = !fsk_mode && descr_en && !det[DET_UNSCR];
        det_match[DET_SCR]   = descr_bit;
        det_seed[DET_SCR]    = 1'b0;
        det_thr[DET_SCR]     = RUN_W'(ONES_LEN);

        det_en[DET_ZERO]     = 1'b1;
        det_match[DET_ZERO]  = !rx_bit;
        det_seed[DET_ZERO]   = 1'b0;
        det_thr[DET_ZERO]    = zero_thr;
    end

    // One run detector per pattern
    for (genvar g = 0; g < NUM_DET; g++) begin : g_det
        rxpd_run_det #(
            .RUN_W     (RUN_W),
            .HOLD_BITS (HOLD_BITS),
            .HOLD_W    (HOLD_W)
        ) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (flush || !det_en[g]),
            .stb   (bit_valid),
            .match (det_match[g]),
            .seed  (det_seed[g]),
            .thr   (det_thr[g]),
            .det   (det[g])
        );
    end

    rxpd_code_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .det_unscr (det[DET_UNSCR]),
        .det_scr   (det[DET_SCR]),
        .det_zero  (det[DET_ZERO]),
        .code      (line_code)
    );

    // Drive the alternation flag straight from its detector
    always_comb begin
        alt_flag = det[DET_ALT];
    end

    // Outside FSK the alternation flag is down by the next edge (R1)
    p_alt_fsk_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fsk_mode |=> !alt_flag);

    // Scrambled and unscrambled detections do not stay on together (R4)
    p_scr_yields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        det[DET_UNSCR] |=> !det[DET_SCR]);

    // A mode or rate change empties both outputs at the next edge (R7)
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!alt_flag && line_code == CODE_IDLE));

    // Descrambled-ones detection needs DPSK/QAM with the descrambler on (R3)
    p_scr_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det[DET_SCR]) |-> $past(!fsk_mode && descr_en));

endmodule

// File: tb/rx_pattern_bank_bench.sv
module rx_pattern_bank_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       rx_bit = 1'b0;
    logic       descr_bit = 1'b0;
    logic       fsk_mode = 1'b1;
    logic       start_stop_en = 1'b0;
    logic       descr_en = 1'b0;
    logic [3:0] char_len = 4'd0;
    logic [1:0] rate_sel = 2'd0;
    logic       alt_flag;
    logic [1:0] line_code;

    typedef struct {
        logic       alt;
        logic [1:0] code;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_pattern_bank u_rx_pattern_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_valid     (bit_valid),
        .rx_bit        (rx_bit),
        .descr_bit     (descr_bit),
        .fsk_mode      (fsk_mode),
        .start_stop_en (start_stop_en),
        .descr_en      (descr_en),
        .char_len      (char_len),
        .rate_sel      (rate_sel),
        .alt_flag      (alt_flag),
        .line_code     (line_code)
    );

    // One strobed bit, then wait until both output stages have updated
    task automatic send_bit(input logic rx, input logic ds);
        @(negedge clk);
        bit_valid = 1'b1;
        rx_bit    = rx;
        descr_bit = ds;
        @(negedge clk);
        bit_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_run(input int n, input logic rx, input logic ds);
        for (int i = 0; i < n; i++) send_bit(rx, ds);
    endtask

    task automatic set_cfg(input logic fsk, input logic ss, input logic de,
                           input logic [3:0] clen, input logic [1:0] rate);
        @(negedge clk);
        fsk_mode      = fsk;
        start_stop_en = ss;
        descr_en      = de;
        char_len      = clen;
        rate_sel      = rate;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Driver side of the scoreboard: queue what the outputs must show now
    task automatic expect_out(input logic alt, input logic [1:0] code, input string tag);
        exp_t e;
        e.alt  = alt;
        e.code = code;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: pop expectations just after the falling edge and compare
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (alt_flag !== e.alt || line_code !== e.code) begin
                    n_fail++;
                    $display("FAIL %s: alt_flag=%0b line_code=%02b, expected alt_flag=%0b line_code=%02b",
                             e.tag, alt_flag, line_code, e.alt, e.code);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_out(1'b0, 2'b00, "R9 reset state idle");

        // R8: a steady one with no strobe never counts
        rx_bit = 1'b1;
        repeat (40) @(negedge clk);
        expect_out(1'b0, 2'b00, "R8 no strobe no count");

        // R1: alternating pattern in FSK, 31 bits then the 32nd
        for (int i = 0; i < 31; i++) send_bit(logic'(i % 2), 1'b0);
        expect_out(1'b0, 2'b00, "R1 31 alternating bits");
        send_bit(1'b1, 1'b0);
        expect_out(1'b1, 2'b00, "R1 32 alternating bits");

        // R6: hold the alternation flag for 12 bits, drop on the 13th
        send_run(12, 1'b1, 1'b0);
        expect_out(1'b1, 2'b00, "R6 alt held 12 bits");
        send_bit(1'b1, 1'b0);
        expect_out(1'b0, 2'b00, "R6 alt dropped on 13th");

        // R2: ones run is now 14; 31 then 32
        send_run(17, 1'b1, 1'b0);
        expect_out(1'b0, 2'b00, "R2 31 ones");
        send_bit(1'b1, 1'b0);
        expect_out(1'b0, 2'b01, "R2 32 ones in FSK");

        // R7: rate change clears a held detection
        set_cfg(1'b1, 1'b0, 1'b0, 4'd0, 2'd1);
        expect_out(1'b0, 2'b00, "R7 rate change clears");

        // R8: one zero in the middle restarts the ones run
        send_run(31, 1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_run(31, 1'b1, 1'b0);
        expect_out(1'b0, 2'b00, "R8 broken run restarts");
        send_bit(1'b1, 1'b0);
        expect_out(1'b0, 2'b01, "R8 full run after restart");

        // R7: mode change to DPSK/QAM clears
        set_cfg(1'b0, 1'b0, 1'b0, 4'd0, 2'd1);
        expect_out(1'b0, 2'b00, "R7 mode change clears");

        // R1: alternation ignored outside FSK
        for (int i = 0; i < 40; i++) send_bit(logic'(i % 2), 1'b0);
        expect_out(1'b0, 2'b00, "R1 no alt flag in DPSK");

        // R3: descrambled ones ignored with descrambler off
        for (int i = 0; i < 32; i++) send_bit(logic'(i % 2), 1'b1);
        expect_out(1'b0, 2'b00, "R3 descrambler off");

        // R3: descrambler on, 31 then 32 descrambled ones
        set_cfg(1'b0, 1'b0, 1'b1, 4'd0, 2'd1);
        for (int i = 0; i < 31; i++) send_bit(logic'(i % 2), 1'b1);
        expect_out(1'b0, 2'b00, "R3 31 descrambled ones");
        send_bit(1'b1, 1'b1);
        expect_out(1'b0, 2'b11, "R3 32 descrambled ones");

        // R4: unscrambled ones take over and keep the code
        send_run(30, 1'b1, 1'b1);
        expect_out(1'b0, 2'b11, "R4 before unscrambled detect");
        send_bit(1'b1, 1'b1);
        expect_out(1'b0, 2'b01, "R4 unscrambled takes over");
        send_run(5, 1'b1, 1'b1);
        expect_out(1'b0, 2'b01, "R4 scrambled stays suppressed");

        // R5: start-stop framing, char_len 3 gives NX = 10
        set_cfg(1'b0, 1'b1, 1'b1, 4'd3, 2'd2);
        send_run(32, 1'b1, 1'b0);
        expect_out(1'b0, 2'b01, "R2 32 ones in DPSK");
        send_run(9, 1'b0, 1'b0);
        expect_out(1'b0, 2'b01, "R6 ones held during 9 zeros");
        send_bit(1'b0, 1'b0);
        expect_out(1'b0, 2'b10, "R5 R9 10 zeros newest wins");

        // R9: zeros held 12 bits, then idle
        send_run(12, 1'b1, 1'b0);
        expect_out(1'b0, 2'b10, "R6 zeros held 12 bits");
        send_bit(1'b1, 1'b0);
        expect_out(1'b0, 2'b00, "R9 idle after holds end");

        // R5: framing has no effect in FSK, threshold back to 32
        set_cfg(1'b1, 1'b1, 1'b1, 4'd3, 2'd2);
        send_run(10, 1'b0, 1'b0);
        expect_out(1'b0, 2'b00, "R5 FSK ignores framing");
        send_run(22, 1'b0, 1'b0);
        expect_out(1'b0, 2'b10, "R5 32 zeros in FSK");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        report();
    end

endmodule